// File: doc/BRIEF.md
# Interrupt Redirection Router

This block sits between a set of device interrupt lines and a group of up to eight CPUs. Every input line has its own routing entry, written by software through a plain indexed write port. An entry selects the vector number to deliver and the trigger type (edge or level). It also holds a mask bit, a delivery style, and a bitmap of target CPUs. When an unmasked input fires, the router forms one message for it and presents it on a valid/ready output. The message carries the vector, the target bitmap and the delivery style.

In fixed delivery the bitmap is copied as written, so one CPU or a broadcast group gets the interrupt. In lowest-priority delivery the router compares the current priority levels that the CPUs report on an input bus. It narrows the bitmap to the single candidate with the smallest level. Level-triggered inputs are delivered once and then stay blocked until an end-of-interrupt carrying the same vector arrives. Several routers can be placed side by side. They share nothing and have no master or slave roles.

Top module: `irq_router`

## Requirements
- R1: After reset every entry is masked with all other fields zero, `msg_valid` is low, and no input activity produces a message until an entry is written.
- R2: A write with `cfg_we` high stores `cfg_data` into entry `cfg_idx`. The field layout is: vector in bits 7:0, mask in bit 8, lowest-priority delivery in bit 9, level trigger in bit 10, and CPU bitmap in bits 18:11. Writes to indices at or above the input count are ignored.
- R3: In fixed delivery (bit 9 = 0), a message carries the entry's vector, `msg_dest` equal to the entry's bitmap, and `msg_lowpri` = 0.
- R4: In lowest-priority delivery (bit 9 = 1), `msg_dest` has exactly one bit set. That bit is the CPU in the entry's bitmap whose 4-bit level in `cpu_prio[4c+3:4c]` is smallest. On a tie the lowest-numbered CPU wins, and `msg_lowpri` = 1.
- R5: A masked input produces no message. An event seen while masked is not remembered once the entry is unmasked.
- R6: An edge-triggered input (bit 10 = 0) produces exactly one message per rising edge. Holding the line high does not repeat it.
- R7: A level-triggered input produces one message and then no further message while its line stays high. It is released again only when `eoi_valid` arrives with `eoi_vec` equal to the entry's vector. An end-of-interrupt for any other vector has no effect.
- R8: While `msg_valid` is high and `msg_ready` is low, the message fields hold steady and `msg_valid` stays high.
- R9: When several inputs are pending together, the lowest-numbered input is delivered first and the others follow in index order.
- R10: An unmasked entry with an all-zero CPU bitmap produces no message.
- R11: Two inputs may use the same vector. Each message still carries the bitmap of its own entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_IN | Interrupt request lines, synchronous to clk |
| cfg_we | input | 1 | Entry write strobe |
| cfg_idx | input | $clog2(NUM_IN) | Entry index for the write |
| cfg_data | input | 19 | Entry contents (layout in R2) |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vec | input | 8 | Vector being retired |
| cpu_prio | input | 8*PRIO_W | Current priority level of each CPU, CPU c at bits [PRIO_W*c +: PRIO_W] |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_vec | output | 8 | Vector delivered |
| msg_dest | output | 8 | Target CPU bitmap |
| msg_lowpri | output | 1 | 1 when the message was resolved by lowest-priority delivery |

## Verification
A wrong pending or remote-block bit in a slot shows at the ports within three clocks of the triggering edge or end-of-interrupt. It appears as a missing message, an extra message while a level line is held, or a message for an input that was masked. A wrong lowest-priority pick shows in `msg_dest` of the very message it produces. Sweeping many priority patterns, including ties, exposes a comparison or tie-order fault. Ordering faults in the pending selector appear as messages arriving out of index order when several lines fire in the same cycle.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  parameter int CPU_N = 8;
  parameter int VEC_W = 8;

  typedef struct packed {
    logic [CPU_N-1:0] dest;
    logic             level;
    logic             lowpri;
    logic             mask;
    logic [VEC_W-1:0] vec;
  } rte_t;

  localparam int RTE_W = $bits(rte_t);

  function automatic rte_t rte_reset();
    rte_t r;
    r      = '0;
    r.mask = 1'b1;
    return r;
  endfunction

  // an entry can deliver only when unmasked and aimed at someone
  function automatic logic rte_live(rte_t e);
    return !e.mask && (e.dest != '0);
  endfunction
endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic irq,
  input  logic live,
  input  logic level,
  input  logic take,
  input  logic eoi_hit,
  output logic pend,
  output logic remote
);
  logic irq_q;
  logic rise;

  assign rise = irq && !irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      pend   <= 1'b0;
      remote <= 1'b0;
    end else begin
      irq_q <= irq;
      if (!level)       remote <= 1'b0;
      else if (take)    remote <= 1'b1;
      else if (eoi_hit) remote <= 1'b0;
      if (!live)        pend <= 1'b0;
      else if (level)   pend <= irq && !remote && !take;
      else              pend <= (pend && !take) || rise;
    end
  end
endmodule

// File: rtl/irq_lowpri_pick.sv
module irq_lowpri_pick #(
  parameter int CPU_N  = 8,
  parameter int PRIO_W = 4
) (
  input  logic [CPU_N-1:0]        cand,
  input  logic [CPU_N*PRIO_W-1:0] prio,
  output logic [CPU_N-1:0]        win
);
  logic              found;
  logic [PRIO_W-1:0] best;
  logic [PRIO_W-1:0] p;

  always_comb begin
    found = 1'b0;
    best  = '1;
    win   = '0;
    p     = '0;
    for (int c = 0; c < CPU_N; c++) begin
      p = prio[c*PRIO_W +: PRIO_W];
      // strict compare keeps the lowest index on a tie
      if (cand[c] && (!found || p < best)) begin
        found  = 1'b1;
        best   = p;
        win    = '0;
        win[c] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_IN = 24,
  parameter int PRIO_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_IN-1:0]          irq_in,
  input  logic                       cfg_we,
  input  logic [$clog2(NUM_IN)-1:0]  cfg_idx,
  input  logic [RTE_W-1:0]           cfg_data,
  input  logic                       eoi_valid,
  input  logic [VEC_W-1:0]           eoi_vec,
  input  logic [CPU_N*PRIO_W-1:0]    cpu_prio,
  output logic                       msg_valid,
  input  logic                       msg_ready,
  output logic [VEC_W-1:0]           msg_vec,
  output logic [CPU_N-1:0]           msg_dest,
  output logic                       msg_lowpri
);
  localparam int IDX_W = $clog2(NUM_IN);

  rte_t              tbl [NUM_IN];
  logic [NUM_IN-1:0] pend_vec;
  logic [NUM_IN-1:0] remote_vec;
  logic [NUM_IN-1:0] take_vec;
  logic [IDX_W-1:0]  sel;
  logic              any_pend;
  logic              slot_free;
  logic              load;
  rte_t              sel_ent;
  logic [CPU_N-1:0]  lp_win;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_IN; i++) tbl[i] <= rte_reset();
    end else if (cfg_we && (int'(cfg_idx) < NUM_IN)) begin
      tbl[cfg_idx] <= rte_t'(cfg_data);
    end
  end

  for (genvar g = 0; g < NUM_IN; g++) begin : g_slot
    irq_src_slot u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .irq     (irq_in[g]),
      .live    (rte_live(tbl[g])),
      .level   (tbl[g].level),
      .take    (take_vec[g]),
      .eoi_hit (eoi_valid && (tbl[g].vec == eoi_vec)),
      .pend    (pend_vec[g]),
      .remote  (remote_vec[g])
    );
    assign take_vec[g] = load && (sel == IDX_W'(g));
  end

  always_comb begin
    sel      = '0;
    any_pend = 1'b0;
    for (int i = NUM_IN - 1; i >= 0; i--) begin
      if (pend_vec[i]) begin
        sel      = IDX_W'(i);
        any_pend = 1'b1;
      end
    end
  end

  assign sel_ent   = tbl[sel];
  assign slot_free = !msg_valid || msg_ready;
  assign load      = any_pend && slot_free;

  irq_lowpri_pick #(.CPU_N(CPU_N), .PRIO_W(PRIO_W)) u_pick (
    .cand (sel_ent.dest),
    .prio (cpu_prio),
    .win  (lp_win)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid  <= 1'b0;
      msg_vec    <= '0;
      msg_dest   <= '0;
      msg_lowpri <= 1'b0;
    end else if (load) begin
      msg_valid  <= 1'b1;
      msg_vec    <= sel_ent.vec;
      msg_dest   <= sel_ent.lowpri ? lp_win : sel_ent.dest;
      msg_lowpri <= sel_ent.lowpri;
    end else if (msg_ready) begin
      msg_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NUM_IN = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [7:0]        msg_vec,
  input logic [7:0]        msg_dest,
  input logic              msg_lowpri,
  input logic [NUM_IN-1:0] take_vec,
  input logic [NUM_IN-1:0] pend_vec,
  input logic [NUM_IN-1:0] remote_vec
);
  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !msg_valid); // R1
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_vec) && $stable(msg_dest) && $stable(msg_lowpri)); // R8
  AST_DEST_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> msg_dest != 8'd0); // R10
  AST_LOWPRI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_lowpri |-> $countones(msg_dest) == 1); // R4
  AST_TAKE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (take_vec & ~pend_vec) == '0); // R9
  AST_TAKE_NOT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (take_vec & remote_vec) == '0); // R7
  AST_TAKE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    take_vec != '0 |=> msg_valid); // R3
endmodule

bind irq_router irq_router_chk #(.NUM_IN(NUM_IN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .msg_valid  (msg_valid),
  .msg_ready  (msg_ready),
  .msg_vec    (msg_vec),
  .msg_dest   (msg_dest),
  .msg_lowpri (msg_lowpri),
  .take_vec   (take_vec),
  .pend_vec   (pend_vec),
  .remote_vec (remote_vec)
);

// File: tb/sim_irq_router.sv
`timescale 1ns/1ps
module sim_irq_router;
  localparam int N  = 24;
  localparam int PW = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] irq_in = '0;
  logic         cfg_we = 1'b0;
  logic [4:0]   cfg_idx = '0;
  logic [18:0]  cfg_data = '0;
  logic         eoi_valid = 1'b0;
  logic [7:0]   eoi_vec = '0;
  logic [31:0]  cpu_prio = '0;
  logic         msg_valid;
  logic         msg_ready = 1'b0;
  logic [7:0]   msg_vec;
  logic [7:0]   msg_dest;
  logic         msg_lowpri;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2 clk = ~clk;

  irq_router #(.NUM_IN(N), .PRIO_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_data(cfg_data), .eoi_valid(eoi_valid), .eoi_vec(eoi_vec), .cpu_prio(cpu_prio),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vec(msg_vec),
    .msg_dest(msg_dest), .msg_lowpri(msg_lowpri)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected < 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  function automatic logic [18:0] mk(logic [7:0] v, logic [7:0] d, logic lvl, logic lp, logic m);
    return {d, lvl, lp, m, v};
  endfunction

  task automatic chk(logic ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int idx, logic [18:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 5'(idx); cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse(logic [N-1:0] m);
    @(negedge clk); irq_in = irq_in | m;
    @(negedge clk); irq_in = irq_in & ~m;
  endtask

  task automatic eoi(logic [7:0] v);
    @(negedge clk); eoi_valid = 1'b1; eoi_vec = v;
    @(negedge clk); eoi_valid = 1'b0;
  endtask

  // wait for a message, compare it, then accept it
  task automatic get_msg(string req, logic [7:0] v, logic [7:0] d, logic lp);
    int n = 0;
    while (!msg_valid && n < 12) begin @(negedge clk); n++; end
    chk(msg_valid && msg_vec == v && msg_dest == d && msg_lowpri == lp, req,
        {7'd0, msg_valid, msg_vec, msg_dest, 7'd0, msg_lowpri},
        {7'd0, 1'b1, v, d, 7'd0, lp});
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  task automatic no_msg(string req, int n);
    logic seen = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (msg_valid) seen = 1'b1;
    end
    chk(!seen, req, {31'd0, seen}, 32'd0);
  endtask

  function automatic logic [7:0] lp_expect(logic [7:0] d, logic [31:0] pr);
    int bi = -1;
    int bp = 99;
    for (int c = 0; c < 8; c++) begin
      int p = int'(pr[c*4 +: 4]);
      if (d[c] && p < bp) begin bp = p; bi = c; end
    end
    return (bi < 0) ? 8'd0 : 8'(1 << bi);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk(!msg_valid, "R1", {31'd0, msg_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    pulse('1);
    no_msg("R1", 8);

    // R2/R3: sweep all inputs in fixed mode, edge trigger
    for (int i = 0; i < N; i++) begin
      logic [7:0] d = 8'(8'h01 << (i % 8)) | 8'(8'h80 >> (i % 5));
      wr(i, mk(8'(8'h20 + i), d, 1'b0, 1'b0, 1'b0));
      pulse(N'(1) << i);
      get_msg("R3", 8'(8'h20 + i), d, 1'b0);
      wr(i, mk(8'h00, 8'h00, 1'b0, 1'b0, 1'b1));
    end

    // R2: out-of-range index write must not alter any entry
    wr(0, mk(8'h11, 8'h03, 1'b0, 1'b0, 1'b0));
    wr(30, mk(8'h99, 8'hFF, 1'b0, 1'b0, 1'b0));
    pulse(24'h1);
    get_msg("R2", 8'h11, 8'h03, 1'b0);

    // R6: held high gives one message only
    pulse(24'h0);
    @(negedge clk); irq_in[0] = 1'b1;
    get_msg("R6", 8'h11, 8'h03, 1'b0);
    no_msg("R6", 10);
    @(negedge clk); irq_in[0] = 1'b0;
    wr(0, mk(8'h00, 8'h00, 1'b0, 1'b0, 1'b1));

    // R5: masked input silent, event forgotten after unmask
    wr(4, mk(8'h33, 8'h02, 1'b0, 1'b0, 1'b1));
    pulse(24'h10);
    no_msg("R5", 8);
    wr(4, mk(8'h33, 8'h02, 1'b0, 1'b0, 1'b0));
    no_msg("R5", 8);

    // R10: zero bitmap silent
    wr(4, mk(8'h34, 8'h00, 1'b0, 1'b0, 1'b0));
    pulse(24'h10);
    no_msg("R10", 8);
    wr(4, mk(8'h00, 8'h00, 1'b0, 1'b0, 1'b1));

    // R4: lowest priority sweep, with ties
    wr(6, mk(8'h60, 8'hFF, 1'b0, 1'b1, 1'b0));
    for (int p = 0; p < 40; p++) begin
      logic [7:0] d = 8'((p * 37 + 90) & 8'hFF) | 8'(1 << (p % 8));
      for (int c = 0; c < 8; c++)
        cpu_prio[c*4 +: 4] = (p % 2 == 0) ? 4'((p * 7 + c * 5 + c * p) % 16) : 4'((c * p) % 3);
      wr(6, mk(8'h60, d, 1'b0, 1'b1, 1'b0));
      pulse(24'h40);
      get_msg("R4", 8'h60, lp_expect(d, cpu_prio), 1'b1);
    end
    wr(6, mk(8'h00, 8'h00, 1'b0, 1'b0, 1'b1));

    // R7: level trigger with end-of-interrupt release
    wr(7, mk(8'h41, 8'h04, 1'b1, 1'b0, 1'b0));
    @(negedge clk); irq_in[7] = 1'b1;
    get_msg("R7", 8'h41, 8'h04, 1'b0);
    no_msg("R7", 10);
    eoi(8'h42);
    no_msg("R7", 8);
    eoi(8'h41);
    get_msg("R7", 8'h41, 8'h04, 1'b0);
    @(negedge clk); irq_in[7] = 1'b0;
    eoi(8'h41);
    no_msg("R7", 8);
    wr(7, mk(8'h00, 8'h00, 1'b0, 1'b0, 1'b1));

    // R8: stall keeps the message steady
    wr(9, mk(8'h77, 8'h81, 1'b0, 1'b0, 1'b0));
    pulse(24'h200);
    repeat (3) @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      chk(msg_valid && msg_vec == 8'h77 && msg_dest == 8'h81, "R8",
          {15'd0, msg_valid, msg_vec, msg_dest}, {15'd0, 1'b1, 8'h77, 8'h81});
      @(negedge clk);
    end
    get_msg("R8", 8'h77, 8'h81, 1'b0);
    wr(9, mk(8'h00, 8'h00, 1'b0, 1'b0, 1'b1));

    // R9: simultaneous events leave in index order
    wr(3, mk(8'h13, 8'h10, 1'b0, 1'b0, 1'b0));
    wr(5, mk(8'h15, 8'h20, 1'b0, 1'b0, 1'b0));
    wr(20, mk(8'h1A, 8'h40, 1'b0, 1'b0, 1'b0));
    pulse(24'h100028);
    get_msg("R9", 8'h13, 8'h10, 1'b0);
    get_msg("R9", 8'h15, 8'h20, 1'b0);
    get_msg("R9", 8'h1A, 8'h40, 1'b0);

    // R11: shared vector, separate bitmaps
    wr(10, mk(8'h55, 8'h01, 1'b0, 1'b0, 1'b0));
    wr(11, mk(8'h55, 8'hF0, 1'b0, 1'b0, 1'b0));
    pulse(24'hC00);
    get_msg("R11", 8'h55, 8'h01, 1'b0);
    get_msg("R11", 8'h55, 8'hF0, 1'b0);
    no_msg("R11", 6);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule